// File: doc/BRIEF.md
# Paged Write Buffer with Self-Timed Commit

This block sits behind the command decoder of a serial memory. It gathers the data bytes of one write command into a 128-byte page buffer. When chip select rises, it decides whether the write is kept. A kept write starts a self-timed cycle. The cycle first reads the current page out of the array and merges it under a per-byte mask, so bytes that were not supplied keep their stored values. It then programs all 128 bytes of the page back into the array.

The decoder gives the block a start strobe with the 16-bit byte address and the state of the write-enable latch, one strobe per complete data byte, and a chip-select rise pulse. The rise pulse carries a flag that says whether it came right after the last bit of a byte. The block returns a busy flag and a one-cycle request to clear the write-enable latch. It drives the read and write ports of the array directly.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `wip`, `wel_clr` and `arr_we` are all low.
- R2: The page is 128 bytes and starts at a multiple of 128. Byte k of a command that started at address A lands at `{A[15:7], (A[6:0]+k) mod 128}`, so the address wraps inside the page.
- R3: A commit happens only on a `cs_rise` with `cs_aligned` = 1. A rise with `cs_aligned` = 0 drops the command: `wip` stays low and the array is not written.
- R4: If `wel` is 0 when `wr_start` is taken, the command is refused. No cycle follows, whatever bytes arrive.
- R5: After a commit, `wip` is high for exactly `T_WRITE` clock cycles, starting in the cycle after the `cs_rise` strobe.
- R6: A cycle writes every byte of the page exactly once, in ascending offset order. Supplied bytes take the new data and all other bytes keep their previous array contents.
- R7: `wel_clr` is a one-cycle pulse in the first cycle after `wip` falls.
- R8: While `wip` is high, `wr_start` and `byte_vld` are ignored.
- R9: A command with no complete data byte never commits, even when the rise is aligned.
- R10: When more than 128 bytes arrive, a later byte at an offset replaces the earlier one, so the last value sent wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Start-of-write strobe from the decoder |
| wr_addr | input | 16 | Byte address of the write, valid with `wr_start` |
| wel | input | 1 | Write-enable latch state, sampled with `wr_start` |
| byte_vld | input | 1 | One complete data byte is present |
| byte_data | input | 8 | Data byte, valid with `byte_vld` |
| cs_rise | input | 1 | Chip-select rise strobe |
| cs_aligned | input | 1 | The rise came right after a full byte, valid with `cs_rise` |
| wip | output | 1 | Write cycle in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| arr_rd_en | output | 1 | Array read enable (one-cycle latency) |
| arr_rd_addr | output | 16 | Array read address |
| arr_rd_data | input | 8 | Array read data, one cycle after `arr_rd_en` |
| arr_we | output | 1 | Array write enable |
| arr_wr_addr | output | 16 | Array write address |
| arr_wr_data | output | 8 | Array write data |

## Verification
The assertions assume the decoder never raises `byte_vld` and `cs_rise` in the same cycle. They also assume the array returns read data exactly one cycle after `arr_rd_en`, and that `T_WRITE` leaves room for a full load pass and a full program pass. The bench respects all three. It spaces strobes one cycle apart through single tasks, models the array with a one-cycle registered read, and sets `T_WRITE` to 400. That is well above the 258-cycle minimum.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef logic [7:0] byte_t;

   function automatic int unsigned min_cycle(input int unsigned page);
      return 2 * page + 2;
   endfunction
endpackage

// File: rtl/pwb_collect.sv
module pwb_collect #(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 7,
   parameter int PAGE   = 128
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wip,
   input  logic                    wr_start,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic                    wel,
   input  logic                    byte_vld,
   input  logic                    cs_rise,
   input  logic                    cs_aligned,
   output logic                    commit,
   output logic [ADDR_W-OFS_W-1:0] page_base,
   output logic                    buf_we,
   output logic [OFS_W-1:0]        buf_idx,
   output logic [PAGE-1:0]         mask
);
   logic             armed;
   logic             got_byte;
   logic [OFS_W-1:0] ptr;
   logic             take_start;

   assign take_start = wr_start && !wip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         got_byte  <= 1'b0;
         ptr       <= '0;
         page_base <= '0;
         mask      <= '0;
      end else if (take_start) begin
         armed     <= wel;
         got_byte  <= 1'b0;
         ptr       <= wr_addr[OFS_W-1:0];
         page_base <= wr_addr[ADDR_W-1:OFS_W];
         mask      <= '0;
      end else begin
         if (byte_vld && armed) begin
            mask[ptr] <= 1'b1;
            ptr       <= ptr + OFS_W'(1);
            got_byte  <= 1'b1;
         end
         if (cs_rise) armed <= 1'b0;
      end
   end

   assign commit  = cs_rise && cs_aligned && armed && got_byte && !wip;
   assign buf_we  = byte_vld && armed && !take_start;
   assign buf_idx = ptr;

   // R8: a start strobe during a cycle must leave the latched page untouched
   a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wip && wr_start) |=> $stable(page_base));
endmodule

// File: rtl/pwb_seq.sv
module pwb_seq #(
   parameter int PAGE    = 128,
   parameter int OFS_W   = 7,
   parameter int T_WRITE = 5000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic [PAGE-1:0]  mask,
   output logic             wip,
   output logic             wel_clr,
   output logic             rd_en,
   output logic [OFS_W-1:0] rd_idx,
   output logic             load_we,
   output logic [OFS_W-1:0] load_idx,
   output logic             prog_we,
   output logic [OFS_W-1:0] prog_idx
);
   localparam int CNT_W = $clog2(T_WRITE + 1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_m1;
   logic [CNT_W-1:0] cnt_mp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip     <= 1'b0;
         wel_clr <= 1'b0;
         cnt     <= '0;
      end else begin
         wel_clr <= 1'b0;
         if (commit) begin
            wip <= 1'b1;
            cnt <= '0;
         end else if (wip) begin
            if (cnt == CNT_W'(T_WRITE - 1)) begin
               wip     <= 1'b0;
               wel_clr <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   assign cnt_m1   = cnt - CNT_W'(1);
   assign cnt_mp   = cnt - CNT_W'(PAGE + 1);
   assign rd_en    = wip && (cnt < CNT_W'(PAGE));
   assign rd_idx   = cnt[OFS_W-1:0];
   assign load_idx = cnt_m1[OFS_W-1:0];
   assign load_we  = wip && (cnt >= CNT_W'(1)) && (cnt <= CNT_W'(PAGE)) && !mask[load_idx];
   assign prog_idx = cnt_mp[OFS_W-1:0];
   assign prog_we  = wip && (cnt >= CNT_W'(PAGE + 1)) && (cnt <= CNT_W'(2 * PAGE));

   // R7: the latch-clear pulse follows directly on the end of a busy period
   a_r7_clr_after_wip: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr |-> (!wip && $past(wip)));

   // R6: consecutive program beats step through the page one offset at a time
   a_r6_prog_order: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_we && $past(prog_we)) |-> (prog_idx == $past(prog_idx) + OFS_W'(1)));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BYTES = 128,
   parameter int T_WRITE    = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wel,
   input  logic              byte_vld,
   input  logic [7:0]        byte_data,
   input  logic              cs_rise,
   input  logic              cs_aligned,
   output logic              wip,
   output logic              wel_clr,
   output logic              arr_rd_en,
   output logic [ADDR_W-1:0] arr_rd_addr,
   input  logic [7:0]        arr_rd_data,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_wr_addr,
   output logic [7:0]        arr_wr_data
);
   import pwb_pkg::*;

   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int PG_W  = ADDR_W - OFS_W;

   if (PAGE_BYTES != (1 << OFS_W)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (T_WRITE < int'(min_cycle(PAGE_BYTES))) begin : g_bad_time
      $error("T_WRITE too short for a load and a program pass");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr
      $error("ADDR_W must exceed the page offset width");
   end

   logic                  commit;
   logic [PG_W-1:0]       page_base;
   logic                  col_we;
   logic [OFS_W-1:0]      col_idx;
   logic [PAGE_BYTES-1:0] mask;
   logic                  ld_we;
   logic [OFS_W-1:0]      ld_idx;
   logic [OFS_W-1:0]      rd_idx;
   logic [OFS_W-1:0]      prog_idx;
   byte_t                 pbuf [PAGE_BYTES];

   pwb_collect #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PAGE(PAGE_BYTES)) u_col (
      .clk(clk), .rst_n(rst_n), .wip(wip),
      .wr_start(wr_start), .wr_addr(wr_addr), .wel(wel),
      .byte_vld(byte_vld), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
      .commit(commit), .page_base(page_base),
      .buf_we(col_we), .buf_idx(col_idx), .mask(mask)
   );

   pwb_seq #(.PAGE(PAGE_BYTES), .OFS_W(OFS_W), .T_WRITE(T_WRITE)) u_seq (
      .clk(clk), .rst_n(rst_n), .commit(commit), .mask(mask),
      .wip(wip), .wel_clr(wel_clr),
      .rd_en(arr_rd_en), .rd_idx(rd_idx),
      .load_we(ld_we), .load_idx(ld_idx),
      .prog_we(arr_we), .prog_idx(prog_idx)
   );

   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   q <= '0;
         else if (col_we && col_idx == OFS_W'(g))      q <= byte_data;
         else if (ld_we && ld_idx == OFS_W'(g))        q <= arr_rd_data;
      end
      assign pbuf[g] = q;
   end

   assign arr_rd_addr = {page_base, rd_idx};
   assign arr_wr_addr = {page_base, prog_idx};
   assign arr_wr_data = pbuf[prog_idx];

   // R3: every busy period is opened by an aligned chip-select rise
   a_r3_rise_opens_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wip) |-> $past(cs_rise && cs_aligned));

   // R6: array writes only happen inside a busy period
   a_r6_write_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> wip);

   // R1: nothing is written while the block holds no cycle
   a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!wip && !$past(wip)) |-> (!arr_we && !wel_clr));
endmodule

// File: tb/page_write_buffer_test.sv
module page_write_buffer_test;
   localparam int TW = 400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_start = 1'b0, wel = 1'b0, byte_vld = 1'b0;
   logic        cs_rise = 1'b0, cs_aligned = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  byte_data = '0;
   logic        wip, wel_clr, arr_rd_en, arr_we;
   logic [15:0] arr_rd_addr, arr_wr_addr;
   logic [7:0]  arr_rd_data, arr_wr_data;

   int nvec = 0;
   int nfail = 0;

   typedef struct packed { logic [15:0] a; logic [7:0] d; } item_t;
   item_t sb[$];

   logic [7:0] mem [1024];

   always #4 clk = ~clk;

   page_write_buffer #(.T_WRITE(TW)) uut (
      .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr), .wel(wel),
      .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
      .wip(wip), .wel_clr(wel_clr), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
      .arr_rd_data(arr_rd_data), .arr_we(arr_we), .arr_wr_addr(arr_wr_addr),
      .arr_wr_data(arr_wr_data)
   );

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7) + 3);
      arr_rd_data = '0;
   end

   always @(posedge clk) begin
      if (arr_rd_en) arr_rd_data <= mem[arr_rd_addr[9:0]];
      if (arr_we)    mem[arr_wr_addr[9:0]] <= arr_wr_data;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops expected writes in order (R6)
   always @(negedge clk) begin
      if (rst_n && arr_we) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R6 unexpected write", int'(arr_wr_addr), 0);
         end else begin
            item_t e;
            e = sb.pop_front();
            chk(arr_wr_addr == e.a && arr_wr_data == e.d, "R6 write beat",
                int'({arr_wr_addr, arr_wr_data}), int'({e.a, e.d}));
         end
      end
   end

   task automatic run_cmd(input logic [15:0] a, input int n, input logic [7:0] seed,
                          input bit en, input bit aligned, input bit expect_commit,
                          input bit poke, input string req);
      logic [7:0] exp [128];
      logic [15:0] base;
      int w;
      int bad;
      base = {a[15:7], 7'd0};
      for (int i = 0; i < 128; i++) exp[i] = mem[base[9:0] + 10'(i)];
      for (int k = 0; k < n; k++) exp[7'(a[6:0] + 7'(k))] = 8'(seed + 8'(k * 3));
      if (expect_commit)
         for (int i = 0; i < 128; i++) sb.push_back({base + 16'(i), exp[i]});
      @(negedge clk);
      wr_start = 1'b1; wr_addr = a; wel = en;
      @(negedge clk);
      wr_start = 1'b0; wel = 1'b0;
      for (int k = 0; k < n; k++) begin
         byte_vld = 1'b1; byte_data = 8'(seed + 8'(k * 3));
         @(negedge clk);
      end
      byte_vld = 1'b0;
      cs_rise = 1'b1; cs_aligned = aligned;
      @(negedge clk);
      cs_rise = 1'b0; cs_aligned = 1'b0;
      if (expect_commit) begin
         w = 0;
         while (wip && w < TW + 20) begin
            if (poke && w == 5) begin wr_start = 1'b1; wr_addr = 16'h0300; wel = 1'b1; end
            if (poke && w == 6) begin wr_start = 1'b0; wel = 1'b0; byte_vld = 1'b1; byte_data = 8'hA5; end
            if (poke && w == 7) byte_vld = 1'b0;
            w++;
            @(negedge clk);
         end
         chk(w == TW, "R5 wip length", w, TW);
         chk(wel_clr == 1'b1, "R7 clear pulse high", int'(wel_clr), 1);
         @(negedge clk);
         chk(wel_clr == 1'b0, "R7 clear pulse one cycle", int'(wel_clr), 0);
         chk(sb.size() == 0, "R6 all beats seen", sb.size(), 0);
         bad = 0;
         for (int i = 0; i < 128; i++) if (mem[base[9:0] + 10'(i)] != exp[i]) bad++;
         chk(bad == 0, req, bad, 0);
      end else begin
         repeat (4) @(negedge clk);
         chk(wip == 1'b0, req, int'(wip), 0);
         chk(wel_clr == 1'b0, req, int'(wel_clr), 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(wip == 1'b0, "R1 wip reset", int'(wip), 0);
      chk(wel_clr == 1'b0, "R1 wel_clr reset", int'(wel_clr), 0);
      chk(arr_we == 1'b0, "R1 arr_we reset", int'(arr_we), 0);
      rst_n = 1'b1;
      run_cmd(16'h0010, 1,   8'h40, 1'b1, 1'b1, 1'b1, 1'b0, "R6 single byte refresh");
      run_cmd(16'h00FE, 4,   8'h11, 1'b1, 1'b1, 1'b1, 1'b0, "R2 wrap in page");
      run_cmd(16'h0105, 130, 8'h22, 1'b1, 1'b1, 1'b1, 1'b0, "R10 last byte wins");
      run_cmd(16'h0180, 128, 8'h33, 1'b1, 1'b1, 1'b1, 1'b0, "R6 full page");
      run_cmd(16'h0200, 3,   8'h44, 1'b1, 1'b0, 1'b0, 1'b0, "R3 misaligned rise");
      run_cmd(16'h0200, 3,   8'h55, 1'b0, 1'b1, 1'b0, 1'b0, "R4 latch clear");
      run_cmd(16'h0280, 0,   8'h66, 1'b1, 1'b1, 1'b0, 1'b0, "R9 no data byte");
      run_cmd(16'h0040, 2,   8'h77, 1'b1, 1'b1, 1'b1, 1'b1, "R6 page with poke");
      // R8: the start and byte poked during the cycle must not arm a commit
      @(negedge clk);
      cs_rise = 1'b1; cs_aligned = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0; cs_aligned = 1'b0;
      repeat (3) @(negedge clk);
      chk(wip == 1'b0, "R8 strobes during cycle ignored", int'(wip), 0);
      chk(sb.size() == 0, "R8 no stray writes", sb.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      nvec++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule